// File: doc/BRIEF.md
# Byte-Serial CRC Engine with Byte Register Access

This block computes a 16-bit or 32-bit cyclic redundancy check on a byte stream that a processor pushes through a small byte-wide register bus. Four byte registers form one 32-bit window onto the running checksum. Depending on one control bit, a write to these registers either loads a byte of the starting value or hands a data byte to the engine.

Data reaches the engine only through the least significant byte register. Each such write advances the checksum by one full byte in the same clock. Bits are taken most significant first, with no reflection and no final inversion. Software may read the checksum at any time to get the value accumulated so far.

The generator polynomial for each width can be programmed, and starts at the usual CCITT value for 16 bits and the usual Ethernet value for 32 bits.

Top module: `crc_byte_engine`

## Requirements
- R1: A synchronous reset sets every checksum byte to 0xFF and the control register to 0x00. The control register sits at address 4: bit 0 selects the width (0 = 16-bit, 1 = 32-bit) and bit 1 selects seed loading. After reset, reading address 4 returns 0x00 and reading the checksum bytes returns 0xFF.
- R2: While control bit 1 is set, a write to address 0, 1, 2 or 3 replaces checksum bits 31:24, 23:16, 15:8 or 7:0 with the written byte. In 16-bit mode only addresses 2 and 3 take effect.
- R3: While control bit 1 is clear, writes to addresses 0, 1 and 2 leave the checksum unchanged.
- R4: While control bit 1 is clear, a write to address 3 advances the checksum by the written byte. The byte is taken MSB first: the feedback is the top checksum bit XOR the data bit, the checksum shifts left by one, and the polynomial is XORed in whenever the feedback is 1. The new value is readable from the next cycle.
- R5: In 16-bit mode, addresses 0 and 1 read 0x00 and the result sits in addresses 2 (high) and 3 (low).
- R6: In 32-bit mode, the result spans addresses 0 (bits 31:24) through 3 (bits 7:0).
- R7: A read is registered. Read data appears in the cycle after the read strobe and holds until the next strobe. A read in the same cycle as a data write to address 3 returns the value before the update.
- R8: Addresses 5 to 8 hold the active width's polynomial, bits 31:24 to 7:0. The 16-bit polynomial resets to 0x1021 and the 32-bit one to 0x04C11DB7. In 16-bit mode, addresses 5 and 6 read 0x00 and ignore writes. The engine uses the programmed polynomial.
- R9: Starting from 0xFFFF, the ASCII bytes "123456789" give 0x29B1 in 16-bit mode. Starting from 0xFFFFFFFF, they give 0x0376E6E7 in 32-bit mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 4 | Byte register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |

## Verification
Several checks run on every cycle: the reset value of the checksum, seed bytes landing in the addressed lane, ignored upper-lane data writes leaving the state still, zero reads of the unused high lanes in 16-bit mode, read data holding between strobes, and the pre-update read of the low lane. The correctness of the byte update against a bit-serial model, the known check values for both widths, polynomial programming and the same-cycle read ordering can only be shown by the bench's directed scenarios.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int CRC_MAX = 32;
  localparam int LANES   = CRC_MAX / BYTE_W;
  localparam int NARROW  = 16;

  localparam logic [ADDR_W-1:0] ADR_B3   = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_B2   = 4'd1;
  localparam logic [ADDR_W-1:0] ADR_B1   = 4'd2;
  localparam logic [ADDR_W-1:0] ADR_B0   = 4'd3;
  localparam logic [ADDR_W-1:0] ADR_CTRL = 4'd4;
  localparam logic [ADDR_W-1:0] ADR_P3   = 4'd5;
  localparam logic [ADDR_W-1:0] ADR_P2   = 4'd6;
  localparam logic [ADDR_W-1:0] ADR_P1   = 4'd7;
  localparam logic [ADDR_W-1:0] ADR_P0   = 4'd8;

  localparam int CTRL_WIDE = 0;
  localparam int CTRL_SEED = 1;
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
  parameter int WIDTH  = 16,
  parameter int BYTE_W = 8
) (
  input  logic [WIDTH-1:0]  crc_in,
  input  logic [WIDTH-1:0]  poly,
  input  logic [BYTE_W-1:0] din,
  output logic [WIDTH-1:0]  crc_out
);
  logic [BYTE_W:0][WIDTH-1:0] stage;

  assign stage[0] = crc_in;

  generate
    for (genvar k = 0; k < BYTE_W; k++) begin : g_bit
      logic fb;
      assign fb = stage[k][WIDTH-1] ^ din[BYTE_W-1-k];
      assign stage[k+1] = {stage[k][WIDTH-2:0], 1'b0} ^ ({WIDTH{fb}} & poly);
    end
  endgenerate

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/crc_acc.sv
module crc_acc
  import crc_eng_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               seed_we,
  input  logic [1:0]         seed_lane,
  input  logic [BYTE_W-1:0]  seed_byte,
  input  logic               upd_en,
  input  logic [CRC_MAX-1:0] upd_val,
  output logic [CRC_MAX-1:0] crc_q
);
  logic [BYTE_W-1:0] lane_q [LANES];

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int LO = BYTE_W * (LANES - 1 - g);
      always_ff @(posedge clk) begin
        if (rst) begin
          lane_q[g] <= '1;
        end else if (upd_en) begin
          lane_q[g] <= upd_val[LO +: BYTE_W];
        end else if (seed_we && (seed_lane == 2'(g))) begin
          lane_q[g] <= seed_byte;
        end
      end
      assign crc_q[LO +: BYTE_W] = lane_q[g];
    end
  endgenerate
endmodule

// File: rtl/crc_cfg_regs.sv
module crc_cfg_regs
  import crc_eng_pkg::*;
#(
  parameter logic [NARROW-1:0]  POLY16_INIT = 16'h1021,
  parameter logic [CRC_MAX-1:0] POLY32_INIT = 32'h04C11DB7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ctrl_we,
  input  logic [1:0]         ctrl_wdata,
  input  logic               poly_we,
  input  logic [1:0]         poly_lane,
  input  logic [BYTE_W-1:0]  poly_byte,
  output logic               wide,
  output logic               seed_mode,
  output logic [NARROW-1:0]  poly16,
  output logic [CRC_MAX-1:0] poly32
);
  logic [1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= ctrl_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      poly16 <= POLY16_INIT;
      poly32 <= POLY32_INIT;
    end else if (poly_we) begin
      if (ctrl_q[CTRL_WIDE]) begin
        poly32[(LANES - 1 - int'(poly_lane)) * BYTE_W +: BYTE_W] <= poly_byte;
      end else if (poly_lane[1]) begin
        poly16[(1 - int'(poly_lane[0])) * BYTE_W +: BYTE_W] <= poly_byte;
      end
    end
  end

  assign wide      = ctrl_q[CTRL_WIDE];
  assign seed_mode = ctrl_q[CTRL_SEED];
endmodule

// File: rtl/crc_byte_engine.sv
module crc_byte_engine
  import crc_eng_pkg::*;
#(
  parameter logic [NARROW-1:0]  POLY16_INIT = 16'h1021,
  parameter logic [CRC_MAX-1:0] POLY32_INIT = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  logic               wide;
  logic               seed_mode;
  logic [NARROW-1:0]  poly16;
  logic [CRC_MAX-1:0] poly32;
  logic [CRC_MAX-1:0] crc_q;
  logic [NARROW-1:0]  next16;
  logic [CRC_MAX-1:0] next32;
  logic [CRC_MAX-1:0] upd_val;
  logic               is_data;
  logic               seed_we;
  logic               upd_en;
  logic               ctrl_we;
  logic               poly_we;
  logic [1:0]         poly_lane;
  logic [BYTE_W-1:0]  rd_mux;
  logic [BYTE_W-1:0]  rdata_q;

  // address decode
  assign is_data = (addr <= ADR_B0);
  assign seed_we = wr_en && is_data && seed_mode && (wide || addr >= ADR_B1);
  assign upd_en  = wr_en && (addr == ADR_B0) && !seed_mode;
  assign ctrl_we = wr_en && (addr == ADR_CTRL);

  always_comb begin
    poly_we   = wr_en;
    poly_lane = 2'd0;
    case (addr)
      ADR_P3:  poly_lane = 2'd0;
      ADR_P2:  poly_lane = 2'd1;
      ADR_P1:  poly_lane = 2'd2;
      ADR_P0:  poly_lane = 2'd3;
      default: poly_we   = 1'b0;
    endcase
  end

  crc_cfg_regs #(
    .POLY16_INIT(POLY16_INIT),
    .POLY32_INIT(POLY32_INIT)
  ) cfg_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl_we   (ctrl_we),
    .ctrl_wdata(wdata[1:0]),
    .poly_we   (poly_we),
    .poly_lane (poly_lane),
    .poly_byte (wdata),
    .wide      (wide),
    .seed_mode (seed_mode),
    .poly16    (poly16),
    .poly32    (poly32)
  );

  crc_byte_step #(.WIDTH(NARROW), .BYTE_W(BYTE_W)) step16_i (
    .crc_in (crc_q[NARROW-1:0]),
    .poly   (poly16),
    .din    (wdata),
    .crc_out(next16)
  );

  crc_byte_step #(.WIDTH(CRC_MAX), .BYTE_W(BYTE_W)) step32_i (
    .crc_in (crc_q),
    .poly   (poly32),
    .din    (wdata),
    .crc_out(next32)
  );

  assign upd_val = wide ? next32 : {crc_q[CRC_MAX-1:NARROW], next16};

  crc_acc acc_i (
    .clk      (clk),
    .rst      (rst),
    .seed_we  (seed_we),
    .seed_lane(addr[1:0]),
    .seed_byte(wdata),
    .upd_en   (upd_en),
    .upd_val  (upd_val),
    .crc_q    (crc_q)
  );

  // read path, registered
  always_comb begin
    case (addr)
      ADR_B3:   rd_mux = wide ? crc_q[31:24] : '0;
      ADR_B2:   rd_mux = wide ? crc_q[23:16] : '0;
      ADR_B1:   rd_mux = crc_q[15:8];
      ADR_B0:   rd_mux = crc_q[7:0];
      ADR_CTRL: rd_mux = {6'd0, seed_mode, wide};
      ADR_P3:   rd_mux = wide ? poly32[31:24] : '0;
      ADR_P2:   rd_mux = wide ? poly32[23:16] : '0;
      ADR_P1:   rd_mux = wide ? poly32[15:8]  : poly16[15:8];
      ADR_P0:   rd_mux = wide ? poly32[7:0]   : poly16[7:0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/crc_byte_engine_chk.sv
module crc_byte_engine_chk
  import crc_eng_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  addr,
  input logic [BYTE_W-1:0]  wdata,
  input logic [BYTE_W-1:0]  rdata,
  input logic [CRC_MAX-1:0] crc_q,
  input logic               seed_mode,
  input logic               wide
);
  // R1: state is all ones after a reset cycle
  a_r1_reset_ones: assert property (@(posedge clk)
    rst |=> (crc_q == 32'hFFFF_FFFF));

  // R2: a seed write to the low lane loads that byte
  a_r2_seed_low: assert property (@(posedge clk) disable iff (rst)
    (wr_en && seed_mode && addr == ADR_B0) |=> (crc_q[7:0] == $past(wdata)));

  // R3: data writes to upper lanes leave the state still
  a_r3_upper_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !seed_mode && addr < ADR_B0) |=> $stable(crc_q));

  // R5: high lanes read zero in 16-bit mode
  a_r5_high_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wide && addr <= ADR_B2) |=> (rdata == '0));

  // R7: low-lane read returns the value held before the edge
  a_r7_read_pre: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADR_B0) |=> (rdata == $past(crc_q[7:0])));

  // R7: read data holds without a strobe
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

bind crc_byte_engine crc_byte_engine_chk chk_i (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata    (wdata),
  .rdata    (rdata),
  .crc_q    (crc_q),
  .seed_mode(seed_mode),
  .wide     (wide)
);

// File: tb/crc_byte_engine_tb_top.sv
`timescale 1ns/1ps
module crc_byte_engine_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mdl;

  always #10 clk = ~clk;

  crc_byte_engine dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [31:0] p,
                                           input int w, input logic [7:0] b);
    logic [31:0] mask;
    logic top;
    mask = (w == 32) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    for (int i = 7; i >= 0; i--) begin
      top = c[w-1] ^ b[i];
      c = (c << 1) & mask;
      if (top) c = c ^ (p & mask);
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic read_crc(output logic [31:0] v);
    logic [7:0] b3, b2, b1, b0;
    bus_rd(4'd0, b3); bus_rd(4'd1, b2); bus_rd(4'd2, b1); bus_rd(4'd3, b0);
    v = {b3, b2, b1, b0};
  endtask

  task automatic feed_string(input logic [31:0] p, input int w);
    string s = "123456789";
    for (int i = 0; i < s.len(); i++) begin
      bus_wr(4'd3, s[i]);
      mdl = ref_step(mdl, p, w, s[i]);
    end
  endtask

  task automatic t_reset();
    logic [7:0] b;
    logic [31:0] v;
    bus_rd(4'd4, b);  check("R1 ctrl reset", b, 8'h00);
    read_crc(v);      check("R1/R5 16-bit reset view", v, 32'h0000_FFFF);
    bus_rd(4'd5, b);  check("R8 poly hi zero in 16-bit", b, 8'h00);
    bus_rd(4'd7, b);  check("R8 poly16 high", b, 8'h10);
    bus_rd(4'd8, b);  check("R8 poly16 low", b, 8'h21);
    bus_wr(4'd4, 8'h01);
    read_crc(v);      check("R1/R6 32-bit reset view", v, 32'hFFFF_FFFF);
    bus_rd(4'd5, b);  v[31:24] = b;
    bus_rd(4'd6, b);  v[23:16] = b;
    bus_rd(4'd7, b);  v[15:8]  = b;
    bus_rd(4'd8, b);  v[7:0]   = b;
    check("R8 poly32 reset", v, 32'h04C1_1DB7);
    bus_wr(4'd4, 8'h00);
  endtask

  task automatic t_check16();
    logic [31:0] v;
    mdl = 32'h0000_FFFF;
    feed_string(32'h1021, 16);
    read_crc(v);
    check("R9 CRC-16 check value", v, 32'h0000_29B1);
    check("R4 CRC-16 vs model", v, mdl);
  endtask

  task automatic t_seed16();
    logic [31:0] v;
    logic [7:0] bytes [3] = '{8'h00, 8'hFF, 8'hA5};
    bus_wr(4'd4, 8'h02);
    bus_wr(4'd0, 8'hAA);
    bus_wr(4'd2, 8'h12);
    bus_wr(4'd3, 8'h34);
    read_crc(v);
    check("R2/R5 16-bit seed, high lanes read zero", v, 32'h0000_1234);
    bus_wr(4'd4, 8'h00);
    bus_wr(4'd0, 8'h11); bus_wr(4'd1, 8'h22); bus_wr(4'd2, 8'h33);
    read_crc(v);
    check("R3 upper data writes ignored", v, 32'h0000_1234);
    mdl = 32'h0000_1234;
    foreach (bytes[i]) begin
      bus_wr(4'd3, bytes[i]);
      mdl = ref_step(mdl, 32'h1021, 16, bytes[i]);
      read_crc(v);
      check("R4 16-bit byte update", v, mdl);
    end
  endtask

  task automatic t_check32();
    logic [31:0] v;
    bus_wr(4'd4, 8'h03);
    for (int a = 0; a < 4; a++) bus_wr(4'(a), 8'hFF);
    bus_wr(4'd4, 8'h01);
    mdl = 32'hFFFF_FFFF;
    feed_string(32'h04C1_1DB7, 32);
    read_crc(v);
    check("R9/R6 CRC-32 check value", v, 32'h0376_E6E7);
    check("R4 CRC-32 vs model", v, mdl);
  endtask

  task automatic t_same_cycle();
    logic [7:0] b;
    logic [31:0] pre;
    pre = mdl;
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; addr = 4'd3; wdata = 8'h5C;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0; b = rdata;
    mdl = ref_step(mdl, 32'h04C1_1DB7, 32, 8'h5C);
    check("R7 same-cycle read gives pre-update", b, pre[7:0]);
    repeat (3) @(negedge clk);
    check("R7 read data held without strobe", rdata, pre[7:0]);
    bus_rd(4'd3, b);
    check("R7 next read gives updated", b, mdl[7:0]);
  endtask

  task automatic t_seed32();
    logic [31:0] v;
    bus_wr(4'd4, 8'h03);
    bus_wr(4'd0, 8'hDE); bus_wr(4'd1, 8'hAD); bus_wr(4'd2, 8'hBE); bus_wr(4'd3, 8'hEF);
    read_crc(v);
    check("R2/R6 32-bit seed all lanes", v, 32'hDEAD_BEEF);
    bus_wr(4'd4, 8'h01);
    bus_wr(4'd3, 8'h31);
    mdl = ref_step(32'hDEAD_BEEF, 32'h04C1_1DB7, 32, 8'h31);
    read_crc(v);
    check("R4/R6 32-bit update from seed", v, mdl);
  endtask

  task automatic t_poly();
    logic [7:0] b;
    logic [31:0] v;
    bus_wr(4'd4, 8'h02);
    bus_wr(4'd2, 8'h00); bus_wr(4'd3, 8'h00);
    bus_wr(4'd4, 8'h00);
    bus_wr(4'd5, 8'h77);
    bus_rd(4'd5, b);
    check("R8 16-bit poly hi write ignored", b, 8'h00);
    bus_wr(4'd7, 8'h80); bus_wr(4'd8, 8'h05);
    bus_rd(4'd7, b); v[15:8] = b;
    bus_rd(4'd8, b); v[7:0]  = b;
    check("R8 poly16 readback", v[15:0], 32'h8005);
    mdl = 32'h0;
    for (int i = 1; i <= 3; i++) begin
      bus_wr(4'd3, 8'(i * 8'h41));
      mdl = ref_step(mdl, 32'h8005, 16, 8'(i * 8'h41));
    end
    read_crc(v);
    check("R8 programmed poly used", v, mdl);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_check16();
    t_seed16();
    t_check32();
    t_same_cycle();
    t_seed32();
    t_poly();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule